// File: doc/BRIEF.md
# Walk-Step Switch and Accumulate Cell

This block is one stage of a systolic chain that advances a random walk by a single step and folds that step's contribution into a running sum. Each token entering the cell carries the current walk state, a row tag, a column tag, a row weight, a staged multiplier, a running walk weight and a partial sum. The cell forwards the state, both tags and the row weight unchanged. It swaps in the row weight as the new staged multiplier when the row tag matches the state. It scales the walk weight by the incoming staged multiplier. When the column tag matches the state, it adds the new walk weight to the partial sum.

All arithmetic is signed two's-complement fixed point. Weights and multipliers are DW bits wide with FRAC fraction bits. The partial sum is AW bits wide. The cell accepts one token per clock and registers every output, so N cells in a row form an N-stage pipeline. A valid bit travels with each token. Idle cycles leave the data registers untouched.

Top module: `walk_step_cell`

## Requirements
- R1: While rst_n is low, out_valid is 0 and every data output is 0.
- R2: One clock after a token is accepted (in_valid high), out_state, out_row_tag, out_col_tag and out_row_wt equal that token's in_state, in_row_tag, in_col_tag and in_row_wt.
- R3: For an accepted token, out_tmp equals in_row_wt when in_row_tag equals in_state. Otherwise out_tmp equals in_tmp.
- R4: For an accepted token, out_walk_wt is the signed product in_walk_wt × in_tmp (the incoming in_tmp, not the selected one), arithmetically shifted right by FRAC bits. The shift rounds toward minus infinity.
- R5: A scaled product above 2^(DW-1)-1 gives out_walk_wt = 2^(DW-1)-1. A scaled product below -2^(DW-1) gives out_walk_wt = -2^(DW-1).
- R6: When in_col_tag equals in_state, out_sum is in_sum plus the new (saturated) walk weight, sign-extended. The result saturates to the AW-bit signed range.
- R7: When in_col_tag differs from in_state, out_sum equals in_sum.
- R8: out_valid equals in_valid delayed by one clock.
- R9: After a clock with in_valid low, every data output keeps the value it had before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Token present on the inputs |
| in_state | input | IDX_W | Current walk state |
| in_row_tag | input | IDX_W | Row tag that selects in_row_wt |
| in_col_tag | input | IDX_W | Column tag that enables accumulation |
| in_row_wt | input | DW | Row weight, signed fixed point |
| in_tmp | input | DW | Staged multiplier, signed fixed point |
| in_walk_wt | input | DW | Running walk weight, signed fixed point |
| in_sum | input | AW | Partial sum, signed fixed point |
| out_valid | output | 1 | Token present on the outputs |
| out_state | output | IDX_W | Forwarded walk state |
| out_row_tag | output | IDX_W | Forwarded row tag |
| out_col_tag | output | IDX_W | Forwarded column tag |
| out_row_wt | output | DW | Forwarded row weight |
| out_tmp | output | DW | Selected staged multiplier |
| out_walk_wt | output | DW | Scaled and saturated walk weight |
| out_sum | output | AW | Updated partial sum |

## Verification
Every result of the cell is due exactly one rising edge after its token is driven. The bench changes inputs on the falling edge and reads the outputs on the next falling edge. Each read therefore compares against the token driven one full cycle earlier, and tokens stream back to back. The sweep covers every pair of 8-bit walk weight and multiplier with match and mismatch of both tags. Separate idle cycles confirm that held values and the dropped valid appear on the same falling-edge sample.

// File: rtl/walk_step_cell.sv
module walk_step_cell #(
  parameter int IDX_W = 4,
  parameter int DW    = 8,
  parameter int FRAC  = 4,
  parameter int AW    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [IDX_W-1:0]     in_state,
  input  logic [IDX_W-1:0]     in_row_tag,
  input  logic [IDX_W-1:0]     in_col_tag,
  input  logic signed [DW-1:0] in_row_wt,
  input  logic signed [DW-1:0] in_tmp,
  input  logic signed [DW-1:0] in_walk_wt,
  input  logic signed [AW-1:0] in_sum,
  output logic                 out_valid,
  output logic [IDX_W-1:0]     out_state,
  output logic [IDX_W-1:0]     out_row_tag,
  output logic [IDX_W-1:0]     out_col_tag,
  output logic signed [DW-1:0] out_row_wt,
  output logic signed [DW-1:0] out_tmp,
  output logic signed [DW-1:0] out_walk_wt,
  output logic signed [AW-1:0] out_sum
);
  localparam int PW = 2 * DW;
  localparam logic signed [PW-1:0] W_HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] W_LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [AW-1:0] S_HI = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] S_LO = {1'b1, {(AW-1){1'b0}}};

  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] wt_nxt, tmp_nxt;
  logic signed [AW:0]   sum_wide;
  logic signed [AW-1:0] sum_sat, sum_nxt;
  logic                 row_hit, col_hit;

  assign row_hit = (in_row_tag == in_state);
  assign col_hit = (in_col_tag == in_state);
  assign tmp_nxt = row_hit ? in_row_wt : in_tmp;

  assign prod   = PW'(in_walk_wt) * PW'(in_tmp);
  assign scaled = prod >>> FRAC;
  assign wt_nxt = (scaled > W_HI) ? W_HI[DW-1:0] :
                  (scaled < W_LO) ? W_LO[DW-1:0] : scaled[DW-1:0];

  assign sum_wide = {in_sum[AW-1], in_sum} + {{(AW-DW+1){wt_nxt[DW-1]}}, wt_nxt};
  assign sum_sat  = (sum_wide[AW] != sum_wide[AW-1]) ? (sum_wide[AW] ? S_LO : S_HI)
                                                     : sum_wide[AW-1:0];
  assign sum_nxt  = col_hit ? sum_sat : in_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_state   <= '0;
      out_row_tag <= '0;
      out_col_tag <= '0;
      out_row_wt  <= '0;
      out_tmp     <= '0;
      out_walk_wt <= '0;
      out_sum     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_state   <= in_state;
        out_row_tag <= in_row_tag;
        out_col_tag <= in_col_tag;
        out_row_wt  <= in_row_wt;
        out_tmp     <= tmp_nxt;
        out_walk_wt <= wt_nxt;
        out_sum     <= sum_nxt;
      end
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  state_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_state == $past(in_state)) && (out_row_wt == $past(in_row_wt)));
  // R3
  row_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_row_tag == in_state) |=> out_tmp == $past(in_row_wt));
  // R7
  sum_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_col_tag != in_state) |=> out_sum == $past(in_sum));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum) && $stable(out_walk_wt) && $stable(out_tmp));
endmodule

// File: tb/walk_step_cell_tb.sv
module walk_step_cell_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [3:0] in_state = '0, in_row_tag = '0, in_col_tag = '0;
  logic signed [7:0] in_row_wt = '0, in_tmp = '0, in_walk_wt = '0;
  logic signed [15:0] in_sum = '0;
  logic out_valid;
  logic [3:0] out_state, out_row_tag, out_col_tag;
  logic signed [7:0] out_row_wt, out_tmp, out_walk_wt;
  logic signed [15:0] out_sum;

  int checks = 0, fails = 0;
  int e_state, e_rtag, e_ctag, e_rwt, e_tmp, e_wt, e_sum;

  always #(CLK_PERIOD/2) clk = ~clk;

  walk_step_cell u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_state(in_state), .in_row_tag(in_row_tag), .in_col_tag(in_col_tag),
    .in_row_wt(in_row_wt), .in_tmp(in_tmp), .in_walk_wt(in_walk_wt), .in_sum(in_sum),
    .out_valid(out_valid), .out_state(out_state), .out_row_tag(out_row_tag),
    .out_col_tag(out_col_tag), .out_row_wt(out_row_wt), .out_tmp(out_tmp),
    .out_walk_wt(out_walk_wt), .out_sum(out_sum));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v > hi) ? hi : (v < lo) ? lo : v;
  endfunction

  // drive one token at a falling edge and compute its expected results
  task automatic put(input int k, input int r, input int c, input int e,
                     input int t, input int w, input int v);
    int p;
    in_valid = 1'b1;
    in_state = 4'(k); in_row_tag = 4'(r); in_col_tag = 4'(c);
    in_row_wt = 8'(e); in_tmp = 8'(t); in_walk_wt = 8'(w); in_sum = 16'(v);
    e_state = k & 15; e_rtag = r & 15; e_ctag = c & 15;
    e_rwt = $signed(in_row_wt);
    e_tmp = (e_rtag == e_state) ? $signed(in_row_wt) : $signed(in_tmp);
    p = ($signed(in_walk_wt) * $signed(in_tmp)) >>> 4;
    e_wt = clampi(p, -128, 127);
    e_sum = (e_ctag == e_state) ? clampi($signed(in_sum) + e_wt, -32768, 32767)
                                : $signed(in_sum);
  endtask

  task automatic look(input bit full);
    chk("R8 valid", int'(out_valid), 1);
    if (full) begin
      chk("R2 state", int'(out_state), e_state);
      chk("R2 row tag", int'(out_row_tag), e_rtag);
      chk("R2 col tag", int'(out_col_tag), e_ctag);
      chk("R2 row wt", int'(out_row_wt), e_rwt);
    end
    chk("R3 tmp", int'(out_tmp), e_tmp);
    chk("R4 R5 walk wt", int'(out_walk_wt), e_wt);
    chk((e_ctag == e_state) ? "R6 sum" : "R7 sum", int'(out_sum), e_sum);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 sum", int'(out_sum), 0);
    chk("R1 walk wt", int'(out_walk_wt), 0);
    chk("R1 tmp", int'(out_tmp), 0);
    chk("R1 state", int'(out_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle valid", int'(out_valid), 0);

    // full sweep of walk weight x multiplier, tags alternating hit/miss
    for (int w = -128; w < 128; w++) begin
      for (int t = -128; t < 128; t++) begin
        int i;
        int k;
        i = (w + 128) * 256 + (t + 128);
        k = i & 15;
        put(k, i[1] ? k : (k ^ 5), i[2] ? k : (k ^ 10), (i >> 3) & 255, t, w,
            (i * 37) & 65535);
        @(negedge clk);
        look(i[3]);
      end
    end

    // R9: idle cycle with different inputs, outputs hold
    put(3, 3, 3, 55, 100, 100, 32000);
    @(negedge clk);
    look(1'b1);
    in_valid = 1'b0;
    in_state = 4'd9; in_row_tag = 4'd9; in_col_tag = 4'd9;
    in_row_wt = -8'sd7; in_tmp = -8'sd90; in_walk_wt = 8'sd77; in_sum = -16'sd5;
    @(negedge clk);
    chk("R8 bubble valid", int'(out_valid), 0);
    chk("R9 hold sum", int'(out_sum), e_sum);
    chk("R9 hold walk wt", int'(out_walk_wt), e_wt);
    chk("R9 hold tmp", int'(out_tmp), e_tmp);
    chk("R9 hold state", int'(out_state), e_state);

    // R6 saturation corners of the sum
    put(1, 2, 1, 0, 127, 127, 32767);
    @(negedge clk);
    chk("R5 high clamp", int'(out_walk_wt), 127);
    chk("R6 sum high clamp", int'(out_sum), 32767);
    put(1, 2, 1, 0, -128, 127, -32768);
    @(negedge clk);
    chk("R5 low clamp", int'(out_walk_wt), -128);
    chk("R6 sum low clamp", int'(out_sum), -32768);
    // R4 floor rounding of a negative product: -1*1 >>> 4 = -1
    put(0, 1, 0, 0, 1, -1, 10);
    @(negedge clk);
    chk("R4 floor", int'(out_walk_wt), -1);
    chk("R6 small add", int'(out_sum), 9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule